// File: doc/BRIEF.md
# Byte-Wide SPI Master with Sticky Status Flags

This block is a serial peripheral interface controller that runs as bus master and moves one byte at a time. A CPU reaches it through a single-cycle read/write strobe bus with three registers: data, control and status. A write to the data register starts an 8-bit exchange. The byte goes out on MOSI most significant bit first, while the byte arriving on MISO is assembled and held for a later data read. The serial clock advances only on pulses of an external clock-enable input, so the bit rate is set by a baud divider outside the block.

Three sticky status flags report the block's state: transfer done, write collision and mode fault. Each flag is cleared only by a two-access software sequence, never by writing the status register. A single interrupt request line combines the transfer-done and mode-fault flags and is gated by an enable bit in the control register. If the slave-select input is pulled low while the block is the enabled master, it treats this as a bus conflict. It drops out of master mode, stops driving its serial outputs and aborts any exchange in progress.

Register addresses are: 0 data, 1 control, 2 status. The control register holds enable in bit 0, master in bit 1 and interrupt enable in bit 2, and its other bits read as zero. The status register is read-only. It holds transfer done in bit 7, write collision in bit 6 and mode fault in bit 4, and its other bits read as zero.

Top module: `spi_master_flags`

## Requirements
- R1: After reset, status reads 0x00, control reads 0x00, irq_o is 0, both output enables are 0 and sck_o is 0.
- R2: With control bits 0 and 1 set, a data write that is accepted sends the byte MSB first. MOSI is stable at each rising SCK edge, and MISO is sampled on the rising edge. One SCK half-period lasts one tick_i pulse and SCK idles low. After 8 bits, a data read returns the received byte and status bit 7 is set.
- R3: Status bit 7 clears when a status read is followed directly by a data read or a data write. A control access between the two breaks the sequence, and then the flag stays set.
- R4: A data write is ignored while status bit 7 is 1. No exchange starts and no collision is flagged.
- R5: A data write while an exchange is running sets status bit 6. The written byte is discarded and the exchange finishes with the original byte. Bit 6 clears through the same sequence as bit 7.
- R6: If ss_ni is low while control bits 0 and 1 are both 1, status bit 4 is set and control bits 0 and 1 are cleared. Both output enables then drop, and a running exchange ends without setting bit 7.
- R7: Status bit 4 clears only when a status read that sees it set is followed directly by a control write. A control write alone does not clear it. A status read followed by a data access and then a control write does not clear it either.
- R8: irq_o is 1 exactly when control bit 2 is 1 and status bit 7 or status bit 4 is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Register select: 0 data, 1 control, 2 status |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register |
| irq_o | output | 1 | Interrupt request |
| tick_i | input | 1 | Serial clock enable from the baud divider |
| sck_o | output | 1 | Serial clock |
| sck_oe_o | output | 1 | Output enable for sck_o |
| mosi_o | output | 1 | Serial data out |
| mosi_oe_o | output | 1 | Output enable for mosi_o |
| miso_i | input | 1 | Serial data in |
| ss_ni | input | 1 | Slave-select input, active low, used to detect a conflict |

## Verification
An armed-sequence bit that is stuck or loses its state has an effect at the ports only on the next status read. That read shows a flag still set when it should have cleared, or cleared when it should still be set. The bench therefore reads status directly after every clearing sequence, and also after every sequence that was deliberately broken. A shift-register or counter fault shows up within one byte time: MOSI carries a different byte, or the received byte read back afterwards is different. A missed mode-fault action shows up within one cycle as output enables that stay high.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int unsigned BUS_W = 8;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  typedef struct packed {
    logic irq_en;
    logic master;
    logic enable;
  } ctrl_t;
endpackage

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         start_i,
  input  logic         abort_i,
  input  logic [W-1:0] load_i,
  input  logic         miso_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         sck_o,
  output logic         mosi_o,
  output logic [W-1:0] rx_o
);
  localparam int unsigned CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sr_q;
  logic [W-1:0]  rx_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q, sck_q, miso_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      rx_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sck_q  <= 1'b0;
      miso_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        busy_q <= 1'b0;
        sck_q  <= 1'b0;
      end else if (start_i) begin
        busy_q <= 1'b1;
        sr_q   <= load_i;
        cnt_q  <= '0;
        sck_q  <= 1'b0;
      end else if (busy_q && tick_i) begin
        if (!sck_q) begin
          sck_q  <= 1'b1;
          miso_q <= miso_i;
        end else begin
          sck_q <= 1'b0;
          sr_q  <= {sr_q[W-2:0], miso_q};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            rx_q   <= {sr_q[W-2:0], miso_q};
          end
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign sck_o  = sck_q;
  assign mosi_o = sr_q[W-1];
  assign rx_o   = rx_q;

  AST_SCK_TOGGLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && tick_i && !abort_i && !start_i) |=> (sck_q != $past(sck_q))); // R2
  AST_SCK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |=> !sck_q); // R2
endmodule

// File: rtl/spi_flags.sv
module spi_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  input  logic wcol_set_i,
  input  logic modf_set_i,
  input  logic stat_rd_i,
  input  logic data_acc_i,
  input  logic ctrl_acc_i,
  input  logic ctrl_wr_i,
  output logic tc_o,
  output logic wcol_o,
  output logic modf_o
);
  logic tc_q, wcol_q, modf_q;
  logic arm_d_q, arm_m_q;
  logic any_acc, clr_d, clr_m;

  assign any_acc = stat_rd_i | data_acc_i | ctrl_acc_i;
  assign clr_d   = arm_d_q & data_acc_i;
  assign clr_m   = arm_m_q & ctrl_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tc_q    <= 1'b0;
      wcol_q  <= 1'b0;
      modf_q  <= 1'b0;
      arm_d_q <= 1'b0;
      arm_m_q <= 1'b0;
    end else begin
      // any access other than the matching second step disarms
      if (stat_rd_i)    arm_d_q <= 1'b1;
      else if (any_acc) arm_d_q <= 1'b0;
      if (stat_rd_i)    arm_m_q <= modf_q;
      else if (any_acc) arm_m_q <= 1'b0;
      // set wins over a clear in the same cycle
      if (done_i)      tc_q <= 1'b1;
      else if (clr_d)  tc_q <= 1'b0;
      if (wcol_set_i)  wcol_q <= 1'b1;
      else if (clr_d)  wcol_q <= 1'b0;
      if (modf_set_i)  modf_q <= 1'b1;
      else if (clr_m)  modf_q <= 1'b0;
    end
  end

  assign tc_o   = tc_q;
  assign wcol_o = wcol_q;
  assign modf_o = modf_q;

  AST_TC_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> tc_q); // R2
  AST_TC_CLEAR_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_d_q && data_acc_i && !done_i) |=> !tc_q); // R3
  AST_MODF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (modf_q && !ctrl_wr_i) |=> modf_q); // R7
endmodule

// File: rtl/spi_master_flags.sv
module spi_master_flags
  import spi_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic             irq_o,
  input  logic             tick_i,
  output logic             sck_o,
  output logic             sck_oe_o,
  output logic             mosi_o,
  output logic             mosi_oe_o,
  input  logic             miso_i,
  input  logic             ss_ni
);
  ctrl_t            ctrl_q;
  logic             data_wr, data_acc, ctrl_wr, ctrl_acc, stat_rd;
  logic             modf_set, start, wcol_set, active;
  logic             busy, done, sck, mosi;
  logic             tc, wcol, modf;
  logic [BUS_W-1:0] rx;

  assign data_wr  = wr_i & (addr_i == ADDR_DATA);
  assign data_acc = (wr_i | rd_i) & (addr_i == ADDR_DATA);
  assign ctrl_wr  = wr_i & (addr_i == ADDR_CTRL);
  assign ctrl_acc = (wr_i | rd_i) & (addr_i == ADDR_CTRL);
  assign stat_rd  = rd_i & (addr_i == ADDR_STAT);

  assign active   = ctrl_q.enable & ctrl_q.master;
  assign modf_set = active & ~ss_ni;
  assign start    = data_wr & ~tc & ~busy & active & ~modf_set;
  assign wcol_set = data_wr & ~tc & busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (modf_set) begin
      ctrl_q.enable <= 1'b0;
      ctrl_q.master <= 1'b0;
      if (ctrl_wr) ctrl_q.irq_en <= wdata_i[2];
    end else if (ctrl_wr) begin
      ctrl_q <= ctrl_t'(wdata_i[2:0]);
    end
  end

  spi_shift #(.W(BUS_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .start_i (start),
    .abort_i (modf_set),
    .load_i  (wdata_i),
    .miso_i  (miso_i),
    .busy_o  (busy),
    .done_o  (done),
    .sck_o   (sck),
    .mosi_o  (mosi),
    .rx_o    (rx)
  );

  spi_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (done),
    .wcol_set_i (wcol_set),
    .modf_set_i (modf_set),
    .stat_rd_i  (stat_rd),
    .data_acc_i (data_acc),
    .ctrl_acc_i (ctrl_acc),
    .ctrl_wr_i  (ctrl_wr),
    .tc_o       (tc),
    .wcol_o     (wcol),
    .modf_o     (modf)
  );

  always_comb begin
    unique case (addr_i)
      ADDR_DATA: rdata_o = rx;
      ADDR_CTRL: rdata_o = {{(BUS_W-3){1'b0}}, ctrl_q};
      ADDR_STAT: rdata_o = {tc, wcol, 1'b0, modf, 4'b0000};
      default:   rdata_o = '0;
    endcase
  end

  assign irq_o     = ctrl_q.irq_en & (tc | modf);
  assign sck_o     = sck;
  assign mosi_o    = mosi;
  assign sck_oe_o  = active;
  assign mosi_oe_o = active;

  AST_MODF_DROPS_MASTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    modf_set |=> (!ctrl_q.enable && !ctrl_q.master && modf)); // R6
  AST_WR_IGNORED_ON_TC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && tc && !busy) |=> !busy); // R4
endmodule

// File: tb/spi_master_flags_tb.sv
module spi_master_flags_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       irq, tick = 1'b0, sck, sck_oe, mosi, mosi_oe, miso, ss_n = 1'b1;

  logic [7:0] slave_sr = '0;
  logic [7:0] mosi_cap = '0;
  int         nbits = 0;
  int         n_chk = 0, n_fail = 0;
  bit         done_flag = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  spi_master_flags u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .tick_i(tick),
    .sck_o(sck), .sck_oe_o(sck_oe), .mosi_o(mosi), .mosi_oe_o(mosi_oe),
    .miso_i(miso), .ss_ni(ss_n)
  );

  assign miso = slave_sr[7];

  initial forever begin
    @(negedge clk);
    tick = ~tick;
  end

  // slave model: capture MOSI on rising SCK, advance MISO on falling SCK
  initial forever begin
    @(posedge sck);
    mosi_cap = {mosi_cap[6:0], mosi};
    nbits++;
  end
  initial forever begin
    @(negedge sck);
    slave_sr = {slave_sr[6:0], 1'b0};
  end

  // monitor: compare reads against the scoreboard, away from the clock edge
  initial forever begin
    @(negedge clk);
    #(CLK_P/4);
    if (rd) begin
      item_t it;
      it = exp_q.pop_front();
      n_chk++;
      if (rdata !== it.exp) begin
        n_fail++;
        $display("FAIL %s: read addr %0d got %02h expected %02h", it.tag, addr, rdata, it.exp);
      end
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    it.exp = exp; it.tag = tag;
    exp_q.push_back(it);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int nb;
    idle(3);
    // R1 reset state
    chk({7'b0, irq},    8'h00, "R1 irq");
    chk({7'b0, sck_oe}, 8'h00, "R1 sck_oe");
    chk({7'b0, sck},    8'h00, "R1 sck");
    rst_n = 1'b1;
    idle(2);
    rd_chk(2'd2, 8'h00, "R1 status");
    rd_chk(2'd1, 8'h00, "R1 ctrl");

    // R2 basic exchange
    wr_reg(2'd1, 8'h07);
    chk({7'b0, mosi_oe}, 8'h01, "R2 mosi_oe");
    slave_sr = 8'h3C;
    wr_reg(2'd0, 8'hA5);
    idle(45);
    chk(mosi_cap, 8'hA5, "R2 mosi byte");
    chk(nbits[7:0], 8'd8, "R2 bit count");
    chk({7'b0, irq}, 8'h01, "R8 irq on done");
    rd_chk(2'd2, 8'h80, "R2 status done");
    rd_chk(2'd0, 8'h3C, "R2 rx byte");
    rd_chk(2'd2, 8'h00, "R3 cleared by status+data read");
    chk({7'b0, irq}, 8'h00, "R8 irq low");

    // R4 write ignored while done flag set; R3 broken sequence
    slave_sr = 8'hC3;
    wr_reg(2'd0, 8'h5A);
    idle(45);
    chk(mosi_cap, 8'h5A, "R2 second byte");
    wr_reg(2'd1, 8'h03);
    chk({7'b0, irq}, 8'h00, "R8 irq gated by enable");
    wr_reg(2'd1, 8'h07);
    chk({7'b0, irq}, 8'h01, "R8 irq re-enabled");
    nb = nbits;
    wr_reg(2'd0, 8'hFF);
    idle(45);
    chk(nbits[7:0], nb[7:0], "R4 no exchange started");
    rd_chk(2'd2, 8'h80, "R4 no collision flagged");
    rd_chk(2'd1, 8'h07, "R3 ctrl read");
    rd_chk(2'd0, 8'hC3, "R4 rx unchanged");
    rd_chk(2'd2, 8'h80, "R3 broken sequence keeps flag");
    wr_reg(2'd0, 8'h11);
    rd_chk(2'd2, 8'h00, "R3 cleared by status+data write");
    chk(nbits[7:0], nb[7:0], "R4 clearing write starts nothing");

    // R5 write collision
    slave_sr = 8'h18;
    wr_reg(2'd0, 8'h81);
    idle(6);
    wr_reg(2'd0, 8'h00);
    rd_chk(2'd2, 8'h40, "R5 collision flag");
    idle(45);
    chk(mosi_cap, 8'h81, "R5 original byte kept");
    rd_chk(2'd2, 8'hC0, "R5 both flags");
    rd_chk(2'd0, 8'h18, "R5 rx byte");
    rd_chk(2'd2, 8'h00, "R5 both cleared");

    // R6 mode fault
    slave_sr = 8'hF0;
    wr_reg(2'd0, 8'h99);
    idle(6);
    @(negedge clk) ss_n = 1'b0;
    idle(2);
    ss_n = 1'b1;
    idle(40);
    rd_chk(2'd2, 8'h10, "R6 fault flag, no done");
    chk({7'b0, sck_oe},  8'h00, "R6 sck_oe released");
    chk({7'b0, mosi_oe}, 8'h00, "R6 mosi_oe released");
    chk({7'b0, irq},     8'h01, "R8 irq on fault");
    rd_chk(2'd1, 8'h04, "R6 ctrl bits cleared");

    // R7 clearing sequence for the fault flag
    wr_reg(2'd1, 8'h04);
    rd_chk(2'd2, 8'h10, "R7 ctrl write alone keeps flag");
    rd_chk(2'd0, 8'h18, "R6 rx untouched by abort");
    wr_reg(2'd1, 8'h04);
    rd_chk(2'd2, 8'h10, "R7 interrupted sequence keeps flag");
    wr_reg(2'd1, 8'h07);
    rd_chk(2'd2, 8'h00, "R7 cleared by status+ctrl write");
    chk({7'b0, irq}, 8'h00, "R8 irq low after clear");

    idle(4);
    finish_run();
  end
endmodule